// File: doc/BRIEF.md
# Phase-Change Memory Array Controller

This block runs every access to an array of one-transistor, one-resistor phase-change cells laid out as 256 rows by 256 columns. The columns form 16 groups of 16. Each group has one sense path and one write driver per column. A host hands over a 12-bit word address, write data, a read/write flag and a mode bit in one cycle. The controller then splits the address into a row and a column-within-group, and runs the access to completion. During that time it shows `busy`, and it marks the end with a one-cycle `done`.

In single-ended mode a word is 16 bits, one bit per group. In differential mode a word is 8 bits. Each bit lives in a pair of groups, with a true cell and a complement cell that always hold opposite values. Both modes use the same 4096 addresses.

Writes drive a per-bit pulse. A one crystallises the cell with a long pulse at the set level. A zero quenches it to the amorphous state with a short pulse at the reset level. After the pulse, the columns are discharged. A read first precharges the columns under read bias, then waits for the sense path to settle, then captures the result. A behavioural cell array stands in for the analog cells so that the block can be exercised end to end.

Top module: `pcm_array_ctrl`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `done`, `err`, `rd_bias_en`, `col_discharge`, `col_precharge` and every bit of `drv_en` and `drv_set` are 0, and `rdata` is 0. Every cell reads back as 0 until it is written.
- R2: A request is accepted on a rising edge where `req_valid` is high and the block is idle. The address is split as follows:
  - `req_addr[11:8]` selects the column inside each group.
  - `req_addr[7:0]` selects the row.
  - In single-ended mode, data bit g maps to column `16*g + req_addr[11:8]`.
- R3: In single-ended mode, a 16-bit word written to an address is returned unchanged by a later read of that address.
- R4: A write pulse starts in the cycle after acceptance. A column whose target value is 1 has its `drv_en` high for SET_CYCLES cycles (13 by default), with `drv_set` high. A column whose target value is 0 has its `drv_en` high for RESET_CYCLES cycles (3 by default), with `drv_set` low. `drv_set` is 0 wherever `drv_en` is 0.
- R5: At most one column per group is driven. Every column outside the addressed column positions is never driven. No driver is on outside the write pulse, and nothing is driven while the block is idle.
- R6: A write has the following sequence after its pulse:
  - `col_discharge` is high for DISCHARGE_CYCLES cycles (4 by default).
  - `done` is then high for exactly one cycle.
  - The pulse phase lasts SET_CYCLES when any cell receives a set pulse, and RESET_CYCLES otherwise. So `busy` lasts 18 or 8 cycles with default values.
- R7: A read has the following sequence:
  - `col_precharge` and `rd_bias_en` are high for PRECHARGE_CYCLES cycles (5 by default).
  - `rd_bias_en` stays high for SENSE_SETTLE_CYCLES cycles (3) and one capture cycle.
  - `done` is then high for one cycle.
  - `busy` lasts 10 cycles with default values.
  - No write driver is ever on while `rd_bias_en` is high.
- R8: Differential mode works as follows:
  - Data bit i uses a true cell in group 2i and a complement cell in group 2i+1, in the same column position.
  - A write puts the set level on the cell whose target value is 1 and the reset level on the other. The true cell takes the bit value and the complement cell takes its inverse.
  - A read returns 1 only when the true cell holds 1 and the complement cell holds 0.
  - `rdata[15:8]` reads as 0.
- R9: `busy` rises in the cycle after acceptance and stays high through the `done` cycle, then falls. `rdata` changes only at the end of a read's capture cycle and otherwise holds its value.
- R10: The following events make `err` high for the following cycle:
  - a `req_valid` seen while busy;
  - a `req_diff` that differs from the mode of the access in flight.
  
  The stray request is dropped without touching the array, and the access in flight finishes in its latched mode.
- R11: A write changes only the cells of its own row and column position. Other addresses keep their data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request strobe, sampled when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_diff | input | 1 | 1 = differential 8-bit words, 0 = single-ended 16-bit words |
| req_addr | input | 12 | Word address: column-in-group on the top 4 bits, row on the low 8 |
| req_wdata | input | 16 | Write data (low 8 bits used in differential mode) |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| err | output | 1 | One-cycle flag for a request or mode change while busy |
| rdata | output | 16 | Captured read data |
| drv_en | output | 256 | Per-column write driver enable (also the write column select) |
| drv_set | output | 256 | Per-column level: 1 = set level, 0 = reset level |
| rd_bias_en | output | 1 | Read bias applied to the selected columns |
| col_discharge | output | 1 | Column discharge after a write |
| col_precharge | output | 1 | Column precharge before sensing |

## Verification
The following properties are checked on every clock edge:
- no driver is on during read bias or while idle;
- each group drives at most one column;
- differential pairs start with opposite levels;
- precharge hands over to sense with bias still applied;
- `done` always follows a discharge or a capture, and sits inside `busy`;
- `rdata` holds between captures.

Several behaviours are shown only by the bench's scenarios against its per-cycle reference model:
- the exact lengths of the set and reset pulses;
- the address-to-column mapping;
- data round trips in both modes, including a differential read of a single-ended word;
- the shortened pulse phase for all-zero writes;
- a dropped request that leaves its target untouched.

// File: rtl/pcm_pkg.sv
package pcm_pkg;

  // Access sequencer states. Writes: IDLE, WPULSE, DISCH, DONE.
  // Reads: IDLE, PRECH, SENSE, CAPT, DONE.
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WPULSE = 3'd1,
    ST_DISCH  = 3'd2,
    ST_PRECH  = 3'd3,
    ST_SENSE  = 3'd4,
    ST_CAPT   = 3'd5,
    ST_DONE   = 3'd6
  } pcm_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Level a cell of a differential pair receives: the true cell takes the bit,
  // the complement cell its inverse.
  function automatic logic pair_level(input logic data_bit, input logic is_comp);
    return data_bit ^ is_comp;
  endfunction

  // Differential sense decision: 1 only when the true cell conducts and the
  // complement cell does not.
  function automatic logic pair_decide(input logic true_cell, input logic comp_cell);
    return true_cell & ~comp_cell;
  endfunction

  // A write needs the long set pulse whenever any addressed cell targets 1.
  function automatic logic needs_set(input logic diff, input logic any_one);
    return diff | any_one;
  endfunction

endpackage

// File: rtl/pcm_seq.sv
module pcm_seq
  import pcm_pkg::*;
#(
  parameter int ADDR_W              = 12,
  parameter int ROW_W               = 8,
  parameter int CSEL_W              = 4,
  parameter int DW                  = 16,
  parameter int CNT_W               = 4,
  parameter int RESET_CYCLES        = 3,
  parameter int SET_CYCLES          = 13,
  parameter int DISCHARGE_CYCLES    = 4,
  parameter int PRECHARGE_CYCLES    = 5,
  parameter int SENSE_SETTLE_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_diff,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              pulse_on,
  output logic [CNT_W-1:0]  pulse_cnt,
  output logic [ROW_W-1:0]  row_q,
  output logic [CSEL_W-1:0] csel_q,
  output logic [DW-1:0]     wdata_q,
  output logic              diff_q,
  output logic              discharge,
  output logic              precharge,
  output logic              rd_bias,
  output logic              capture
);

  localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESET_CYCLES - 1);
  localparam logic [CNT_W-1:0] SET_LAST = CNT_W'(SET_CYCLES - 1);
  localparam logic [CNT_W-1:0] DIS_LAST = CNT_W'(DISCHARGE_CYCLES - 1);
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRECHARGE_CYCLES - 1);
  localparam logic [CNT_W-1:0] SNS_LAST = CNT_W'(SENSE_SETTLE_CYCLES - 1);

  pcm_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] wp_last;
  logic             mode_clash;
  logic             stray_req;

  assign wp_last    = needs_set(diff_q, |wdata_q) ? SET_LAST : RST_LAST;
  assign busy       = (st != ST_IDLE);
  assign stray_req  = busy && req_valid;
  assign mode_clash = busy && (req_diff != diff_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      row_q   <= '0;
      csel_q  <= '0;
      wdata_q <= '0;
      diff_q  <= 1'b0;
      err     <= 1'b0;
    end else begin
      err <= stray_req || mode_clash;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            row_q   <= req_addr[ROW_W-1:0];
            csel_q  <= req_addr[ADDR_W-1:ROW_W];
            wdata_q <= req_wdata;
            diff_q  <= req_diff;
            cnt     <= '0;
            st      <= req_write ? ST_WPULSE : ST_PRECH;
          end
        end
        ST_WPULSE: begin
          if (cnt == wp_last) begin
            cnt <= '0;
            st  <= ST_DISCH;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DISCH: begin
          if (cnt == DIS_LAST) begin
            cnt <= '0;
            st  <= ST_DONE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PRECH: begin
          if (cnt == PRE_LAST) begin
            cnt <= '0;
            st  <= ST_SENSE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SENSE: begin
          if (cnt == SNS_LAST) begin
            cnt <= '0;
            st  <= ST_CAPT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_CAPT: st <= ST_DONE;
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign done      = (st == ST_DONE);
  assign pulse_on  = (st == ST_WPULSE);
  assign pulse_cnt = cnt;
  assign discharge = (st == ST_DISCH);
  assign precharge = (st == ST_PRECH);
  assign capture   = (st == ST_CAPT);
  assign rd_bias   = (st == ST_PRECH) || (st == ST_SENSE) || (st == ST_CAPT);

  // R9: done only ever appears inside a busy window
  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  // R9: busy only drops right after the done cycle
  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

  // R6, R7: every completion is preceded by a discharge or a capture
  p_done_framed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(discharge) || $past(capture)));

  // R7: precharge hands over to sensing with the read bias still on
  p_pre_then_sense_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(precharge) |-> rd_bias);

endmodule

// File: rtl/pcm_drv.sv
module pcm_drv
  import pcm_pkg::*;
#(
  parameter int GROUPS       = 16,
  parameter int GROUP_COLS   = 16,
  parameter int CSEL_W       = 4,
  parameter int CNT_W        = 4,
  parameter int RESET_CYCLES = 3,
  parameter int SET_CYCLES   = 13
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pulse_on,
  input  logic [CNT_W-1:0]             pulse_cnt,
  input  logic [CSEL_W-1:0]            csel,
  input  logic [GROUPS-1:0]            wdata,
  input  logic                         diff,
  output logic [GROUPS*GROUP_COLS-1:0] drv_en,
  output logic [GROUPS*GROUP_COLS-1:0] drv_set
);

  // GROUPS is expected to be even so that every group has a pair partner.
  localparam int                 PAIRS = GROUPS / 2;
  localparam logic [CNT_W-1:0]   SET_N = CNT_W'(SET_CYCLES);
  localparam logic [CNT_W-1:0]   RST_N = CNT_W'(RESET_CYCLES);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic lvl;
    logic run;

    // Target level for this group's selected column
    assign lvl = diff ? pair_level(wdata[g/2], 1'(g % 2)) : wdata[g];
    // Long pulse for set targets, short pulse for reset targets
    assign run = pulse_on && (lvl ? (pulse_cnt < SET_N) : (pulse_cnt < RST_N));

    for (genvar k = 0; k < GROUP_COLS; k++) begin : g_col
      logic hit;
      assign hit                         = run && (csel == CSEL_W'(k));
      assign drv_en[g*GROUP_COLS + k]    = hit;
      assign drv_set[g*GROUP_COLS + k]   = hit && lvl;
    end

    // R5: a group never drives more than one column
    p_col_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(drv_en[g*GROUP_COLS +: GROUP_COLS]));
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int TB = 2 * p * GROUP_COLS;
    localparam int CB = (2 * p + 1) * GROUP_COLS;

    // R8: at pulse start, both cells of a pair are driven to opposite levels
    p_pair_opposite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (diff && pulse_on && pulse_cnt == '0) |->
        ((drv_en[TB +: GROUP_COLS] == drv_en[CB +: GROUP_COLS]) &&
         ((drv_set[TB +: GROUP_COLS] ^ drv_set[CB +: GROUP_COLS]) == drv_en[TB +: GROUP_COLS])));
  end

endmodule

// File: rtl/pcm_sense.sv
module pcm_sense
  import pcm_pkg::*;
#(
  parameter int GROUPS     = 16,
  parameter int GROUP_COLS = 16,
  parameter int CSEL_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         capture,
  input  logic                         diff,
  input  logic [CSEL_W-1:0]            csel,
  input  logic [GROUPS*GROUP_COLS-1:0] row_bits,
  output logic [GROUPS-1:0]            rdata
);

  localparam int PAIRS = GROUPS / 2;

  logic [GROUPS-1:0] sel_bit;
  logic [PAIRS-1:0]  pair_bit;
  logic [GROUPS-1:0] sensed;

  // One sense path per group: pick the addressed column
  for (genvar g = 0; g < GROUPS; g++) begin : g_path
    logic [GROUP_COLS-1:0] grp_bits;
    assign grp_bits   = row_bits[g*GROUP_COLS +: GROUP_COLS];
    assign sel_bit[g] = grp_bits[csel];
  end

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    assign pair_bit[p] = pair_decide(sel_bit[2*p], sel_bit[2*p+1]);
  end

  always_comb begin
    sensed = '0;
    if (diff) sensed[PAIRS-1:0] = pair_bit;
    else      sensed = sel_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata <= '0;
    else if (capture) rdata <= sensed;
  end

  // R8: a differential capture leaves the upper data half clear
  p_diff_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && diff) |=> (rdata[GROUPS-1:PAIRS] == '0));

  // R9: read data moves only on a capture
  p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(rdata));

endmodule

// File: rtl/pcm_cell_array.sv
module pcm_cell_array #(
  parameter int ROWS  = 256,
  parameter int COLS  = 256,
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ROW_W-1:0] row,
  input  logic [COLS-1:0]  drv_en,
  input  logic [COLS-1:0]  drv_set,
  input  logic             rd_bias,
  output logic [COLS-1:0]  row_bits
);

  // Behavioural stand-in for the phase-change cells: 1 = crystalline (set),
  // 0 = amorphous (reset). A driven column takes the level it is driven to.
  logic [COLS-1:0] cells [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) cells[r] <= '0;
    end else begin
      for (int c = 0; c < COLS; c++) begin
        if (drv_en[c]) cells[row][c] <= drv_set[c];
      end
    end
  end

  // Cells only conduct toward the sense paths while read bias is applied
  assign row_bits = rd_bias ? cells[row] : '0;

  // R7: programming current never coincides with read bias
  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bias |-> (drv_en == '0));

endmodule

// File: rtl/pcm_array_ctrl.sv
module pcm_array_ctrl
  import pcm_pkg::*;
#(
  parameter int ROWS                = 256,
  parameter int GROUPS              = 16,
  parameter int GROUP_COLS          = 16,
  parameter int RESET_CYCLES        = 3,
  parameter int SET_CYCLES          = 13,
  parameter int DISCHARGE_CYCLES    = 4,
  parameter int PRECHARGE_CYCLES    = 5,
  parameter int SENSE_SETTLE_CYCLES = 3,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int CSEL_W = $clog2(GROUP_COLS),
  localparam int ADDR_W = ROW_W + CSEL_W,
  localparam int COLS   = GROUPS * GROUP_COLS,
  localparam int DW     = GROUPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_diff,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DW-1:0]     rdata,
  output logic [COLS-1:0]   drv_en,
  output logic [COLS-1:0]   drv_set,
  output logic              rd_bias_en,
  output logic              col_discharge,
  output logic              col_precharge
);

  localparam int MAXC  = max_of(max_of(RESET_CYCLES, SET_CYCLES),
                                max_of(max_of(DISCHARGE_CYCLES, PRECHARGE_CYCLES),
                                       SENSE_SETTLE_CYCLES));
  localparam int CNT_W = $clog2(MAXC + 1);

  logic              pulse_on;
  logic [CNT_W-1:0]  pulse_cnt;
  logic [ROW_W-1:0]  row_q;
  logic [CSEL_W-1:0] csel_q;
  logic [DW-1:0]     wdata_q;
  logic              diff_q;
  logic              capture;
  logic [COLS-1:0]   row_bits;

  pcm_seq #(
    .ADDR_W(ADDR_W), .ROW_W(ROW_W), .CSEL_W(CSEL_W), .DW(DW), .CNT_W(CNT_W),
    .RESET_CYCLES(RESET_CYCLES), .SET_CYCLES(SET_CYCLES),
    .DISCHARGE_CYCLES(DISCHARGE_CYCLES), .PRECHARGE_CYCLES(PRECHARGE_CYCLES),
    .SENSE_SETTLE_CYCLES(SENSE_SETTLE_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_diff(req_diff),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err),
    .pulse_on(pulse_on), .pulse_cnt(pulse_cnt),
    .row_q(row_q), .csel_q(csel_q), .wdata_q(wdata_q), .diff_q(diff_q),
    .discharge(col_discharge), .precharge(col_precharge),
    .rd_bias(rd_bias_en), .capture(capture)
  );

  pcm_drv #(
    .GROUPS(GROUPS), .GROUP_COLS(GROUP_COLS), .CSEL_W(CSEL_W), .CNT_W(CNT_W),
    .RESET_CYCLES(RESET_CYCLES), .SET_CYCLES(SET_CYCLES)
  ) u_drv (
    .clk(clk), .rst_n(rst_n),
    .pulse_on(pulse_on), .pulse_cnt(pulse_cnt), .csel(csel_q),
    .wdata(wdata_q), .diff(diff_q),
    .drv_en(drv_en), .drv_set(drv_set)
  );

  pcm_cell_array #(
    .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W)
  ) u_cells (
    .clk(clk), .rst_n(rst_n), .row(row_q),
    .drv_en(drv_en), .drv_set(drv_set), .rd_bias(rd_bias_en),
    .row_bits(row_bits)
  );

  pcm_sense #(
    .GROUPS(GROUPS), .GROUP_COLS(GROUP_COLS), .CSEL_W(CSEL_W)
  ) u_sense (
    .clk(clk), .rst_n(rst_n), .capture(capture), .diff(diff_q),
    .csel(csel_q), .row_bits(row_bits), .rdata(rdata)
  );

  // R5: an idle controller drives nothing into the array
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((drv_en == '0) && !rd_bias_en && !col_discharge && !col_precharge));

endmodule

// File: tb/pcm_array_ctrl_tb_top.sv
`timescale 1ns/1ps
module pcm_array_ctrl_tb_top;

  localparam int RSTC = 3;
  localparam int SETC = 13;
  localparam int DISC = 4;
  localparam int PREC = 5;
  localparam int SETL = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic         req_diff = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [15:0]  req_wdata = '0;
  logic         busy, done, err, rd_bias_en, col_discharge, col_precharge;
  logic [15:0]  rdata;
  logic [255:0] drv_en, drv_set;

  always #2 clk = ~clk;

  pcm_array_ctrl #(
    .RESET_CYCLES(RSTC), .SET_CYCLES(SETC), .DISCHARGE_CYCLES(DISC),
    .PRECHARGE_CYCLES(PREC), .SENSE_SETTLE_CYCLES(SETL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_diff(req_diff), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .err(err), .rdata(rdata),
    .drv_en(drv_en), .drv_set(drv_set), .rd_bias_en(rd_bias_en),
    .col_discharge(col_discharge), .col_precharge(col_precharge)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit ended   = 1'b0;

  task automatic chk(input string rq, input string what,
                     input logic [255:0] act, input logic [255:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit [255:0] mref [256];
  bit         m_busy, m_wr, m_diff, m_err;
  int         m_t, m_total, m_plen;
  bit [11:0]  m_addr;
  bit [15:0]  m_wd, m_rd;

  function automatic bit tgt_level(bit diff, bit [15:0] wd, int g);
    if (diff) return (g % 2 == 0) ? wd[g/2] : ~wd[g/2];
    return wd[g];
  endfunction

  function automatic bit [15:0] ref_read(bit diff, bit [11:0] a);
    bit [15:0] sb;
    bit [15:0] r;
    r = '0;
    for (int g = 0; g < 16; g++) sb[g] = mref[a[7:0]][g*16 + int'(a[11:8])];
    if (diff) begin
      for (int i = 0; i < 8; i++) r[i] = sb[2*i] && !sb[2*i+1];
    end else r = sb;
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < 256; r++) mref[r] = '0;
      m_busy = 0; m_err = 0; m_t = 0; m_rd = '0; m_diff = 0; m_wr = 0;
    end else begin
      m_err = 0;
      if (m_busy) begin
        if (req_valid || (req_diff != m_diff)) m_err = 1;
        m_t++;
        if (!m_wr && m_t == PREC + SETL + 1) m_rd = ref_read(m_diff, m_addr);
        if (m_t == m_total) m_busy = 0;
      end else if (req_valid) begin
        m_busy = 1; m_t = 0;
        m_wr = req_write; m_diff = req_diff; m_addr = req_addr; m_wd = req_wdata;
        if (m_wr) begin
          m_plen  = (m_diff || (m_wd != 0)) ? SETC : RSTC;
          m_total = m_plen + DISC + 1;
          for (int g = 0; g < 16; g++)
            mref[m_addr[7:0]][g*16 + int'(m_addr[11:8])] = tgt_level(m_diff, m_wd, g);
        end else begin
          m_total = PREC + SETL + 2;
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !ended) begin
      logic [255:0] e_en, e_set;
      bit lv;
      int c;
      e_en = '0; e_set = '0;
      if (m_busy && m_wr && m_t < m_plen) begin
        for (int g = 0; g < 16; g++) begin
          lv = tgt_level(m_diff, m_wd, g);
          c  = g*16 + int'(m_addr[11:8]);
          if (lv ? (m_t < SETC) : (m_t < RSTC)) begin
            e_en[c] = 1'b1; e_set[c] = lv;
          end
        end
      end
      chk("R9", "busy", busy, m_busy);
      chk("R6", "done", done, m_busy && (m_t == m_total - 1));
      chk("R5", "drv_en", drv_en, e_en);
      chk("R4", "drv_set", drv_set, e_set);
      chk("R6", "col_discharge", col_discharge,
          m_busy && m_wr && m_t >= m_plen && m_t < m_plen + DISC);
      chk("R7", "col_precharge", col_precharge, m_busy && !m_wr && m_t < PREC);
      chk("R7", "rd_bias_en", rd_bias_en, m_busy && !m_wr && m_t < PREC + SETL + 1);
      chk("R9", "rdata", rdata, m_rd);
      chk("R10", "err", err, m_err);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_idle(output int bc);
    bc = 0;
    while (busy && !ended) begin
      bc++;
      @(negedge clk);
    end
  endtask

  task automatic access(input bit wr, input bit diff, input bit [11:0] a,
                        input bit [15:0] d, output int bc);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_diff = diff; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle(bc);
  endtask

  initial begin
    int bc;
    int n_set_on, n_rst_on;
    logic [255:0] e_first;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "err", err, 0);
    chk("R1", "rdata", rdata, 0);
    chk("R1", "drv_en", drv_en, 0);
    chk("R1", "bias", {rd_bias_en, col_discharge, col_precharge}, 0);
    access(0, 0, 12'h123, 0, bc);
    chk("R1", "unwritten cell read", rdata, 16'h0000);

    // R3, R6, R7: single-ended round trip with busy lengths
    access(1, 0, 12'h5A3, 16'hA5C3, bc);
    chk("R6", "write busy cycles", bc, 18);
    access(0, 0, 12'h5A3, 0, bc);
    chk("R7", "read busy cycles", bc, 10);
    chk("R3", "read back 5A3", rdata, 16'hA5C3);

    // R2, R4: column decode and per-bit pulse lengths
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_diff = 1'b0;
    req_addr = 12'h721; req_wdata = 16'h0001;
    @(negedge clk);
    req_valid = 1'b0;
    e_first = '0;
    for (int g = 0; g < 16; g++) e_first[g*16 + 7] = 1'b1;
    chk("R2", "first pulse cycle columns", drv_en, e_first);
    chk("R2", "first pulse cycle levels", drv_set, 256'h80);
    n_set_on = 0; n_rst_on = 0; bc = 0;
    while (busy && !ended) begin
      if (drv_en[7])  n_set_on++;
      if (drv_en[23]) n_rst_on++;
      bc++;
      @(negedge clk);
    end
    chk("R4", "set pulse length", n_set_on, SETC);
    chk("R4", "reset pulse length", n_rst_on, RSTC);
    chk("R9", "rdata held across write", rdata, 16'hA5C3);

    // R6, R4: all-zero write uses the short pulse phase only
    access(1, 0, 12'h000, 16'h0000, bc);
    chk("R6", "reset-only write busy cycles", bc, 8);
    access(1, 0, 12'hFFF, 16'hFFFF, bc);
    chk("R6", "all-ones write busy cycles", bc, 18);
    access(0, 0, 12'hFFF, 0, bc);
    chk("R3", "read back FFF", rdata, 16'hFFFF);
    access(0, 0, 12'h000, 0, bc);
    chk("R3", "read back 000", rdata, 16'h0000);

    // R8: differential mode
    access(1, 1, 12'h310, 16'hFF96, bc);
    chk("R8", "diff write busy cycles", bc, 18);
    access(0, 1, 12'h310, 0, bc);
    chk("R8", "diff read back", rdata, 16'h0096);
    access(0, 0, 12'h310, 0, bc);
    chk("R8", "pair cells seen single-ended", rdata, 16'h6996);
    access(0, 1, 12'h5A3, 0, bc);
    chk("R8", "diff read of single-ended word", rdata, 16'h0030);

    // R10: stray request and mode change while busy
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_diff = 1'b0;
    req_addr = 12'h042; req_wdata = 16'h1234;
    @(negedge clk);
    req_addr = 12'h043; req_wdata = 16'hFFFF;
    @(negedge clk);
    chk("R10", "err after stray request", err, 1);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "err clears", err, 0);
    req_diff = 1'b1;
    @(negedge clk);
    chk("R10", "err after mode change", err, 1);
    req_diff = 1'b0;
    wait_idle(bc);
    access(0, 0, 12'h043, 0, bc);
    chk("R10", "dropped request left target", rdata, 16'h0000);
    access(0, 0, 12'h042, 0, bc);
    chk("R10", "in-flight write kept its mode", rdata, 16'h1234);

    // R11: earlier words undisturbed
    access(0, 0, 12'h5A3, 0, bc);
    chk("R11", "5A3 intact", rdata, 16'hA5C3);
    access(0, 0, 12'h721, 0, bc);
    chk("R11", "721 intact", rdata, 16'h0001);
    access(0, 0, 12'h721 ^ 12'h001, 0, bc);
    chk("R11", "neighbour row untouched", rdata, 16'h0000);

    repeat (3) @(negedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !ended) begin
      ended = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL R9 watchdog: actual busy=%0b expected access to end", busy);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule